// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access and Refresh Controller

This block connects a simple host request port to a dynamic memory array of 2048 rows by 2048 columns, each location 4 bits wide. A host request carries a 22-bit word address. The controller splits that address into a row half and a column half. It presents the two halves one after the other on a shared 11-bit address bus. A row select line frames the whole access and a column select line marks the column phase. Write data and a write enable go out during the column phase. Read data is captured at the end of that phase and returned to the host together with a one-cycle ready pulse.

A free-running interval timer, loaded from an input, raises a refresh request. The controller then opens and closes one row, chosen by an internal row counter, without any column phase. This reads the row into the sense amplifiers and writes it back. The row counter advances after each refresh and wraps from the last row to row 0. A pending refresh wins over a host request that is waiting. A refresh never cuts into an access that has already started. After reset, row 0 is refreshed before any host access is served.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: The row half of the address, `host_addr[21:11]`, appears on `mem_addr` in the cycle before the column select. The column half, `host_addr[10:0]`, appears on `mem_addr` in the cycle in which `mem_col_sel` is high.
- R2: An access episode keeps `mem_row_sel` high for exactly 3 consecutive cycles: row, column, restore. `mem_col_sel` is high only in the second of those cycles.
- R3: `mem_wr` is high only in the column cycle of a write, and it carries `host_wdata` on `mem_wdata`. A read returns the `mem_rdata` value sampled in its column cycle. `host_rvalid` is high together with `host_ready` for reads only, never for writes.
- R4: `host_ready` is a single-cycle pulse in the cycle after the column cycle. With no refresh pending, the ready cycle is the third cycle after the clock edge that accepts the request.
- R5: A refresh episode holds `mem_row_sel` high for exactly 2 cycles, with no column select and no write. `mem_addr` holds the refresh row throughout.
- R6: Refreshed rows follow the order 0, 1, 2, and so on, one row per refresh, wrapping from 2047 back to 0.
- R7: With an interval value N of at least 3 and no host traffic, refresh episodes begin exactly N cycles apart. An interval of 0 or 1 requests a refresh every cycle.
- R8: A pending refresh takes priority over a waiting host request. If a refresh is requested every cycle, a held request is never served. It is served once the interval is made long again.
- R9: A refresh that becomes due during an access waits until that access has finished. Accesses interleaved with frequent refreshes return correct data.
- R10: After reset, the first row activity is a refresh of row 0. No host request completes before that refresh ends.
- R11: While reset is asserted, `mem_row_sel`, `mem_col_sel`, `mem_wr`, `host_ready` and `host_rvalid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_interval | input | 16 | Cycles between refresh requests |
| host_req | input | 1 | Access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address, row in upper 11 bits |
| host_wdata | input | 4 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rvalid | output | 1 | Read data valid, with host_ready |
| host_rdata | output | 4 | Read data |
| mem_addr | output | 11 | Shared row/column address bus |
| mem_row_sel | output | 1 | Row select, high while a row is open |
| mem_col_sel | output | 1 | Column select |
| mem_wr | output | 1 | Write enable for the column cycle |
| mem_wdata | output | 4 | Data to the array |
| mem_rdata | input | 4 | Data from the array |

## Verification
The bench builds the block with its default geometry of 11 row bits, 11 column bits and 4 data bits. This keeps the full 2048-row refresh sequence and its wrap from 2047 to 0 within a few thousand cycles, at an interval of 4. The interval is changed at run time to several values. A value of 1 starves the host and so exposes the refresh priority. A value of 7 interleaves refreshes tightly with back-to-back accesses. A value of 20 makes the refresh spacing measurable, and a value of 1000 lets the data-path table run mostly undisturbed. The array is modelled with a small memory indexed by the low row and column bits. This lets written values be read back at corner addresses such as the last row and the last column.

// File: rtl/dram_ctl_pkg.sv
// Shared types for the DRAM access/refresh controller.
// Assumes: one sequencer owns the memory pins; states are few and fixed.
package dram_ctl_pkg;

    // Sequencer states: host access path and refresh path
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ROW      = 3'd1,
        ST_COL      = 3'd2,
        ST_DONE     = 3'd3,
        ST_RF_OPEN  = 3'd4,
        ST_RF_CLOSE = 3'd5
    } ctl_state_t;

    // Which source drives the shared address pins
    typedef enum logic [1:0] {
        AS_ROW = 2'd0,
        AS_COL = 2'd1,
        AS_REF = 2'd2
    } addr_src_t;

endpackage

// File: rtl/dram_refresh_timer.sv
// Refresh interval timer.
// Counts clock cycles and raises a sticky refresh request every
// 'interval' cycles; the request drops when the sequencer grants it.
// Assumes: an interval of 0 or 1 means "request every cycle".
// After reset the request is already set, so row 0 is refreshed first.
module dram_refresh_timer #(
    parameter int IVL_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IVL_BITS-1:0] interval,
    input  logic                grant,
    output logic                pending
);
    logic [IVL_BITS-1:0] count_q;
    logic                fire;

    // Interval reached when the next count would meet the programmed value
    always_comb begin
        fire = ({1'b0, count_q} + {{IVL_BITS{1'b0}}, 1'b1}) >= {1'b0, interval};
    end

    // Free-running count and sticky request flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            pending <= 1'b1;
        end else begin
            count_q <= fire ? '0 : count_q + 1'b1;
            pending <= fire | (pending & ~grant);
        end
    end
endmodule

// File: rtl/dram_refresh_row.sv
// Refresh row counter.
// Holds the row that the next refresh opens; steps by one per refresh
// and wraps after the last row of the array.
// Assumes: the row count is a power of two given by ROW_BITS.
module dram_refresh_row #(
    parameter int ROW_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    output logic [ROW_BITS-1:0] row
);
    localparam logic [ROW_BITS-1:0] LAST_ROW = {ROW_BITS{1'b1}};

    // Step through the rows in order, wrapping at the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (advance) begin
            row <= (row == LAST_ROW) ? '0 : row + 1'b1;
        end
    end
endmodule

// File: rtl/dram_addr_mux.sv
// Shared address pin multiplexer.
// Places the latched row, the latched column or the refresh row on the
// narrow address bus, zero-extended to the pin width.
// Assumes: PIN_BITS is at least as wide as both ROW_BITS and COL_BITS.
module dram_addr_mux
    import dram_ctl_pkg::*;
#(
    parameter int ROW_BITS = 11,
    parameter int COL_BITS = 11,
    parameter int PIN_BITS = 11
) (
    input  addr_src_t           src,
    input  logic [ROW_BITS-1:0] host_row,
    input  logic [COL_BITS-1:0] host_col,
    input  logic [ROW_BITS-1:0] ref_row,
    output logic [PIN_BITS-1:0] pins
);
    // Select one source and widen it to the pin bus
    always_comb begin
        pins = '0;
        unique case (src)
            AS_COL:  pins[COL_BITS-1:0] = host_col;
            AS_REF:  pins[ROW_BITS-1:0] = ref_row;
            default: pins[ROW_BITS-1:0] = host_row;
        endcase
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
// DRAM access and refresh controller (top).
// Accepts host reads and writes on a req/ready port and turns each one into
// a row phase, a column phase and a restore phase on a shared address bus.
// Periodic refresh opens and closes one row per request, without a column
// phase. A pending refresh wins over a waiting host request, but never
// interrupts an access in flight.
// Assumes: the host holds req, we, addr and wdata stable until ready.
// The array returns read data combinationally during the column select.
module dram_refresh_ctrl
    import dram_ctl_pkg::*;
#(
    parameter int ROW_BITS  = 11,
    parameter int COL_BITS  = 11,
    parameter int DATA_BITS = 4,
    parameter int IVL_BITS  = 16,
    localparam int ADDR_BITS = ROW_BITS + COL_BITS,
    localparam int PIN_BITS  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IVL_BITS-1:0]  refresh_interval,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [ADDR_BITS-1:0] host_addr,
    input  logic [DATA_BITS-1:0] host_wdata,
    output logic                 host_ready,
    output logic                 host_rvalid,
    output logic [DATA_BITS-1:0] host_rdata,
    output logic [PIN_BITS-1:0]  mem_addr,
    output logic                 mem_row_sel,
    output logic                 mem_col_sel,
    output logic                 mem_wr,
    output logic [DATA_BITS-1:0] mem_wdata,
    input  logic [DATA_BITS-1:0] mem_rdata
);
    ctl_state_t           state_q, state_d;
    logic [ROW_BITS-1:0]  row_q;
    logic [COL_BITS-1:0]  col_q;
    logic                 we_q;
    logic [DATA_BITS-1:0] wdata_q;
    logic [DATA_BITS-1:0] rdata_q;
    logic                 ref_pending;
    logic                 ref_grant;
    logic                 ref_advance;
    logic [ROW_BITS-1:0]  ref_row;
    logic                 accept;
    addr_src_t            addr_src;

    dram_refresh_timer #(.IVL_BITS(IVL_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (refresh_interval),
        .grant    (ref_grant),
        .pending  (ref_pending)
    );

    dram_refresh_row #(.ROW_BITS(ROW_BITS)) u_rowcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ref_advance),
        .row     (ref_row)
    );

    dram_addr_mux #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .PIN_BITS (PIN_BITS)
    ) u_mux (
        .src      (addr_src),
        .host_row (row_q),
        .host_col (col_q),
        .ref_row  (ref_row),
        .pins     (mem_addr)
    );

    // Next-state logic: refresh first, then host, fixed-length phases
    always_comb begin
        state_d     = state_q;
        ref_grant   = 1'b0;
        ref_advance = 1'b0;
        accept      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    ref_grant = 1'b1;
                    state_d   = ST_RF_OPEN;
                end else if (host_req) begin
                    accept  = 1'b1;
                    state_d = ST_ROW;
                end
            end
            ST_ROW:      state_d = ST_COL;
            ST_COL:      state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            ST_RF_OPEN:  state_d = ST_RF_CLOSE;
            ST_RF_CLOSE: begin
                ref_advance = 1'b1;
                state_d     = ST_IDLE;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request fields when an access is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            row_q   <= host_addr[ADDR_BITS-1:COL_BITS];
            col_q   <= host_addr[COL_BITS-1:0];
            we_q    <= host_we;
            wdata_q <= host_wdata;
        end
    end

    // Sample array data at the end of the column phase
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (state_q == ST_COL) rdata_q <= mem_rdata;
    end

    // Pin and host outputs decoded from the registered state
    always_comb begin
        mem_row_sel = (state_q != ST_IDLE);
        mem_col_sel = (state_q == ST_COL);
        mem_wr      = (state_q == ST_COL) && we_q;
        mem_wdata   = mem_wr ? wdata_q : '0;
        host_ready  = (state_q == ST_DONE);
        host_rvalid = (state_q == ST_DONE) && !we_q;
        host_rdata  = host_rvalid ? rdata_q : '0;
        if (state_q == ST_RF_OPEN || state_q == ST_RF_CLOSE) addr_src = AS_REF;
        else if (state_q == ST_COL)                          addr_src = AS_COL;
        else                                                 addr_src = AS_ROW;
    end
endmodule

// File: rtl/dram_ctl_checker.sv
// Protocol checker for the DRAM access/refresh controller.
// Watches only the pins and host handshake; bound into every instance.
module dram_ctl_checker (
    input logic clk,
    input logic rst_n,
    input logic host_ready,
    input logic host_rvalid,
    input logic mem_row_sel,
    input logic mem_col_sel,
    input logic mem_wr
);
    // R1: column phase follows a row phase of the same episode
    p_col_after_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_col_sel |-> (mem_row_sel && $past(mem_row_sel) && !$past(mem_col_sel)));

    // R2: column select lasts a single cycle
    p_col_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_col_sel |=> !mem_col_sel);

    // R2: an opened row stays open for at least a second cycle
    p_row_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_row_sel) |=> mem_row_sel);

    // R3: writes happen only in a column cycle
    p_write_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_col_sel);

    // R3: read valid only together with ready
    p_rvalid_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> host_ready);

    // R4: a column cycle is followed by ready, with the row still open
    p_col_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_col_sel |=> (host_ready && mem_row_sel));

    // R4: ready comes only right after a column cycle
    p_ready_after_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> $past(mem_col_sel));

    // R4: ready is a one-cycle pulse
    p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
endmodule

bind dram_refresh_ctrl dram_ctl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_row_sel (mem_row_sel),
    .mem_col_sel (mem_col_sel),
    .mem_wr      (mem_wr)
);

// File: tb/dram_refresh_ctrl_test.sv
// Self-checking bench for dram_refresh_ctrl.
module dram_refresh_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] refresh_interval = 16'd1000;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [21:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [3:0]  host_rdata;
    logic [10:0] mem_addr;
    logic        mem_row_sel, mem_col_sel, mem_wr;
    logic [3:0]  mem_wdata, mem_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    dram_refresh_ctrl uut (
        .clk(clk), .rst_n(rst_n), .refresh_interval(refresh_interval),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_row_sel(mem_row_sel),
        .mem_col_sel(mem_col_sel), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Small array model indexed by low row and column bits
    logic [3:0]  bmem [64];
    logic [10:0] lat_row = '0;
    logic        row_prev = 1'b0;
    initial for (int i = 0; i < 64; i++) bmem[i] = 4'h0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_row_sel && !row_prev) lat_row <= mem_addr;
        row_prev <= mem_row_sel;
        if (mem_col_sel && mem_wr) bmem[{lat_row[2:0], mem_addr[2:0]}] <= mem_wdata;
    end
    assign mem_rdata = mem_col_sel ? bmem[{lat_row[2:0], mem_addr[2:0]}] : 4'h0;

    // Episode monitor: classifies each row-open period as access or refresh
    bit          in_epi = 0;
    int          epi_len, epi_cols, epi_col_pos, epi_start;
    logic [10:0] epi_row;
    bit          epi_addr_bad;
    int          epi_bad = 0, ord_bad = 0, ref_count = 0;
    int          prev_ref_start = 0, last_spacing = 0;
    int          exp_ref_row = 0;
    bit          wrapped = 0, first_done = 0, first_was_ref = 0;
    logic [10:0] first_row = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_row_sel) begin
                if (!in_epi) begin
                    in_epi = 1; epi_len = 1; epi_row = mem_addr; epi_cols = 0;
                    epi_col_pos = 0; epi_start = cyc; epi_addr_bad = 0;
                end else begin
                    epi_len++;
                end
                if (mem_col_sel) begin epi_cols++; epi_col_pos = epi_len; end
                if (mem_wr && !mem_col_sel) epi_bad++;
                if (!mem_col_sel && epi_cols == 0 && mem_addr != epi_row) epi_addr_bad = 1;
            end else if (in_epi) begin
                in_epi = 0;
                if (!first_done) begin
                    first_done = 1; first_was_ref = (epi_cols == 0); first_row = epi_row;
                end
                if (epi_cols == 0) begin
                    if (epi_len != 2 || epi_addr_bad) epi_bad++;
                    if (int'(epi_row) != exp_ref_row) ord_bad++;
                    if (epi_row == 11'd0 && ref_count > 0) wrapped = 1;
                    exp_ref_row = (exp_ref_row + 1) % 2048;
                    ref_count++;
                    last_spacing = epi_start - prev_ref_start;
                    prev_ref_start = epi_start;
                end else if (epi_len != 3 || epi_cols != 1 || epi_col_pos != 2) begin
                    epi_bad++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [21:0] a, input logic [3:0] wd,
                          output logic [3:0] rd, output logic rv,
                          output logic [10:0] rs, output logic [10:0] cs, output int n);
        logic [10:0] prev;
        @(negedge clk);
        host_req = 1; host_we = we; host_addr = a; host_wdata = wd;
        n = 0; rs = '0; cs = '0; prev = mem_addr;
        do begin
            @(negedge clk);
            n++;
            if (mem_col_sel) begin rs = prev; cs = mem_addr; end
            prev = mem_addr;
        end while (!host_ready && n < 300);
        rd = host_rdata; rv = host_rvalid;
        host_req = 0;
    endtask

    // {we, addr[21:0], wdata, expected read}
    localparam logic [30:0] VEC [12] = '{
        {1'b1, 22'h002803, 4'hA, 4'h0},
        {1'b1, 22'h3FFFFF, 4'h5, 4'h0},
        {1'b1, 22'h000001, 4'hF, 4'h0},
        {1'b1, 22'h201156, 4'h3, 4'h0},
        {1'b0, 22'h002803, 4'h0, 4'hA},
        {1'b0, 22'h3FFFFF, 4'h0, 4'h5},
        {1'b0, 22'h000001, 4'h0, 4'hF},
        {1'b0, 22'h201156, 4'h0, 4'h3},
        {1'b1, 22'h002803, 4'h6, 4'h0},
        {1'b0, 22'h002803, 4'h0, 4'h6},
        {1'b0, 22'h002803, 4'h0, 4'h6},
        {1'b0, 22'h3FFFFF, 4'h0, 4'h5}
    };

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] rd; logic rv; logic [10:0] rs, cs; int n;
        int base; bit seen;

        // R11: outputs quiet during reset
        repeat (3) @(negedge clk);
        check(!mem_row_sel && !mem_col_sel && !mem_wr && !host_ready && !host_rvalid,
              "R11 reset outputs", {mem_row_sel, mem_col_sel, mem_wr, host_ready}, 0);

        // R10: request raised at reset release waits for refresh of row 0
        @(negedge clk);
        rst_n = 1;
        access(1'b0, 22'h002803, 4'h0, rd, rv, rs, cs, n);
        check(first_done && first_was_ref, "R10 first episode is refresh", first_was_ref, 1);
        check(first_row == 11'd0, "R10 first refresh row", first_row, 0);
        check(n > 3, "R10 access delayed by initial refresh", n, 4);
        check(rv && rd == 4'h0, "R3 initial read", rd, 0);

        // Table walk: R1 address split, R3 data path
        foreach (VEC[i]) begin
            access(VEC[i][30], VEC[i][29:8], VEC[i][7:4], rd, rv, rs, cs, n);
            check(rs == VEC[i][29:19], "R1 row pins", rs, VEC[i][29:19]);
            check(cs == VEC[i][18:8], "R1 column pins", cs, VEC[i][18:8]);
            check(rv == !VEC[i][30], "R3 rvalid only on reads", rv, !VEC[i][30]);
            if (!VEC[i][30]) check(rd == VEC[i][3:0], "R3 read data", rd, VEC[i][3:0]);
        end

        // R4: latency 3 right after a refresh
        base = ref_count;
        for (int k = 0; k < 1200 && ref_count == base; k++) @(negedge clk);
        access(1'b0, 22'h000001, 4'h0, rd, rv, rs, cs, n);
        check(n == 3, "R4 access latency", n, 3);
        check(rd == 4'hF, "R3 read after refresh", rd, 4'hF);

        // R7: refresh spacing equals interval
        refresh_interval = 16'd20;
        repeat (120) @(negedge clk);
        check(last_spacing == 20, "R7 refresh spacing", last_spacing, 20);

        // R8: refresh every cycle starves a held request
        refresh_interval = 16'd1;
        base = ref_count;
        @(negedge clk);
        host_req = 1; host_we = 0; host_addr = 22'h3FFFFF;
        seen = 0;
        repeat (60) begin @(negedge clk); if (host_ready) seen = 1; end
        check(!seen, "R8 request held off by refresh", seen, 0);
        check(ref_count - base >= 15, "R8 refreshes keep running", ref_count - base, 15);
        refresh_interval = 16'd1000;
        seen = 0;
        for (int k = 0; k < 50 && !seen; k++) begin
            @(negedge clk);
            if (host_ready) begin seen = 1; rd = host_rdata; end
        end
        host_req = 0;
        check(seen && rd == 4'h5, "R8 request served after interval restored", rd, 5);

        // R9: accesses interleaved with frequent refreshes
        refresh_interval = 16'd7;
        base = ref_count;
        for (int k = 0; k < 6; k++) begin
            access(1'b0, 22'h201156, 4'h0, rd, rv, rs, cs, n);
            check(rd == 4'h3 && rv, "R9 read amid refreshes", rd, 3);
        end
        check(ref_count > base, "R9 refreshes occurred", ref_count - base, 1);

        // R6: full sweep and wrap of refresh rows
        refresh_interval = 16'd4;
        base = ref_count;
        for (int k = 0; k < 12000 && ref_count < base + 2100; k++) @(negedge clk);
        check(wrapped, "R6 refresh row wrapped", wrapped, 1);
        check(ord_bad == 0, "R6 refresh row order", ord_bad, 0);

        // R2/R5: episode shapes over the whole run
        refresh_interval = 16'd1000;
        repeat (10) @(negedge clk);
        check(epi_bad == 0, "R2 R5 episode shapes", epi_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule